// File: doc/BRIEF.md
# Per-Pad Boundary Scan Register Chain

This block is the data-register portion of a boundary-scan path for a row of bidirectional I/O pads. Every pad owns three scan cells. One sees the value arriving from the pad, one sees the value the core wants to drive, and one sees the core's drive-enable. Each cell is a shift flop with a capture-or-shift selector in front of it. Behind the flop sits a level-sensitive hold latch that keeps the last value loaded.

A test-access controller, not part of this block, sequences the chain. It supplies serial input data, a select between capture and shift, an advance enable standing in for the data-register clock, an update strobe and a test-mode select. The chain returns serial data at its far end. With test mode on, the pad output value and the pad drive-enable come from the hold latches. With test mode off, the core drives the pad directly. The number of pads is a parameter.

Top module: `bscan_pad_chain`

## Requirements
- R1: After synchronous reset, every shift flop and every hold latch is 0, so `tdo` reads 0 and, in test mode, every `pad_out` and `pad_oe` bit reads 0.
- R2: On a rising `clk` with `dr_step`=1 and `dr_shift`=1, every chain position takes the value of the position above it. `tdi` enters the top position (3·NPADS−1), and `tdo` always shows position 0.
- R3: On a rising `clk` with `dr_step`=1 and `dr_shift`=0, each pad k loads three positions: position 3k gets `core_oe[k]`, position 3k+1 gets `core_out[k]` and position 3k+2 gets `pad_in[k]`.
- R4: With `dr_step`=0, the chain keeps its contents whatever `dr_shift` and `tdi` do.
- R5: While `dr_upd`=1 and no shift is under way, every hold latch follows its shift flop. Otherwise the latches keep their value, and this includes the case where `dr_upd` is high during a shift.
- R6: With `test_mode`=1, `pad_out[k]` equals the latch of position 3k+1 and `pad_oe[k]` equals the latch of position 3k. They stay steady while `dr_upd` stays low.
- R7: With `test_mode`=0, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`, whatever the chain holds.
- R8: The chain is exactly 3·NPADS positions long. A bit entered at `tdi` shows at `tdo` after 3·NPADS shift steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chain clock |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial data into the top of the chain |
| dr_shift | input | 1 | 1 = shift, 0 = capture parallel values |
| dr_step | input | 1 | Advance enable for the shift flops |
| dr_upd | input | 1 | Level update strobe for the hold latches |
| test_mode | input | 1 | Pads take their values from the hold latches |
| core_out | input | NPADS | Output value wanted by the core |
| core_oe | input | NPADS | Drive-enable wanted by the core |
| pad_in | input | NPADS | Value seen at each pad |
| pad_out | output | NPADS | Value driven onto each pad |
| pad_oe | output | NPADS | Drive-enable applied to each pad |
| tdo | output | 1 | Serial data out of position 0 |

## Verification
The bench raises the update strobe while a shift is under way. A design that does not gate the latches would let the pad values ripple with every shift step. Captured patterns are made different for each pad and each cell, so a design that swaps the input, output and enable slots, or reverses the pad order, shows wrong bits at `tdo`. Two patterns are shifted in back to back to catch a chain one position too short or too long. The bench also clears test mode while the latches hold nonzero data, which catches a pad selector that leaks scan values into normal operation.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  localparam int unsigned CELLS_PER_PAD = 3;

  // Slot order inside one pad group, counted from the tdo side.
  typedef enum logic [1:0] {
    SLOT_OE  = 2'd0,
    SLOT_OUT = 2'd1,
    SLOT_IN  = 2'd2
  } slot_e;
endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap_shift,
  input  logic step,
  input  logic upd,
  input  logic par_in,
  input  logic ser_in,
  output logic ser_q,
  output logic upd_q
);
  logic shifting;
  logic gate;

  assign shifting = step && cap_shift;
  assign gate     = upd && !shifting;

  always_ff @(posedge clk) begin
    if (rst)       ser_q <= 1'b0;
    else if (step) ser_q <= cap_shift ? ser_in : par_in;
  end

  // Level-sensitive hold stage.
  always_latch begin
    if (rst)       upd_q <= 1'b0;
    else if (gate) upd_q <= ser_q;
  end

  p_shift_move_r2: assert property (@(posedge clk) disable iff (rst)
    (step && cap_shift) |=> (ser_q == $past(ser_in)));

  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !cap_shift) |=> (ser_q == $past(par_in)));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ser_q));

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (shifting && $past(shifting)) |-> $stable(upd_q));
endmodule

// File: rtl/bscan_pad_group.sv
module bscan_pad_group
  import bscan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cap_shift,
  input  logic step,
  input  logic upd,
  input  logic test_mode,
  input  logic ser_in,
  output logic ser_out,
  input  logic core_out,
  input  logic core_oe,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe
);
  localparam int unsigned NC = CELLS_PER_PAD;

  logic [NC:0]   link;
  logic [NC-1:0] par;
  logic [NC-1:0] held;

  assign par[int'(SLOT_OE)]  = core_oe;
  assign par[int'(SLOT_OUT)] = core_out;
  assign par[int'(SLOT_IN)]  = pad_in;

  assign link[NC] = ser_in;
  assign ser_out  = link[0];

  for (genvar s = 0; s < NC; s++) begin : g_cell
    bscan_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .cap_shift (cap_shift),
      .step      (step),
      .upd       (upd),
      .par_in    (par[s]),
      .ser_in    (link[s+1]),
      .ser_q     (link[s]),
      .upd_q     (held[s])
    );
  end

  assign pad_out = test_mode ? held[int'(SLOT_OUT)] : core_out;
  assign pad_oe  = test_mode ? held[int'(SLOT_OE)]  : core_oe;

  p_pad_steady_r6: assert property (@(posedge clk) disable iff (rst)
    (test_mode && !upd && $past(test_mode && !upd))
      |-> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: rtl/bscan_pad_chain.sv
module bscan_pad_chain
  import bscan_pkg::*;
#(
  parameter int unsigned NPADS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tdi,
  input  logic             dr_shift,
  input  logic             dr_step,
  input  logic             dr_upd,
  input  logic             test_mode,
  input  logic [NPADS-1:0] core_out,
  input  logic [NPADS-1:0] core_oe,
  input  logic [NPADS-1:0] pad_in,
  output logic [NPADS-1:0] pad_out,
  output logic [NPADS-1:0] pad_oe,
  output logic             tdo
);
  localparam int unsigned CHAIN_LEN = NPADS * CELLS_PER_PAD;

  logic [NPADS:0] link;

  assign link[NPADS] = tdi;
  assign tdo         = link[0];

  for (genvar k = 0; k < NPADS; k++) begin : g_pad
    bscan_pad_group u_pad (
      .clk       (clk),
      .rst       (rst),
      .cap_shift (dr_shift),
      .step      (dr_step),
      .upd       (dr_upd),
      .test_mode (test_mode),
      .ser_in    (link[k+1]),
      .ser_out   (link[k]),
      .core_out  (core_out[k]),
      .core_oe   (core_oe[k]),
      .pad_in    (pad_in[k]),
      .pad_out   (pad_out[k]),
      .pad_oe    (pad_oe[k])
    );
  end

  p_normal_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && $stable(core_out) && $stable(core_oe))
      |-> ($stable(pad_out) && $stable(pad_oe)));

  initial begin
    assert (CHAIN_LEN == 3 * NPADS) else $error("chain length mismatch R8");
  end
endmodule

// File: tb/sim_bscan_pad_chain.sv
`timescale 1ns/1ps
module sim_bscan_pad_chain;
  localparam int unsigned NPADS = 4;
  localparam int unsigned L = 3 * NPADS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tdi = 1'b0, dr_shift = 1'b0, dr_step = 1'b0, dr_upd = 1'b0, test_mode = 1'b0;
  logic [NPADS-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [NPADS-1:0] pad_out, pad_oe;
  logic tdo;

  int checks = 0;
  int errors = 0;

  logic [L-1:0] m_sr  = '0;
  logic [L-1:0] m_lat = '0;
  logic  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  bscan_pad_chain #(.NPADS(NPADS)) u0 (
    .clk(clk), .rst(rst), .tdi(tdi), .dr_shift(dr_shift), .dr_step(dr_step),
    .dr_upd(dr_upd), .test_mode(test_mode), .core_out(core_out),
    .core_oe(core_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .tdo(tdo)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares tdo against the scoreboard one cycle after each push.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {31'd0, tdo}, {31'd0, e});
    end
  end

  // Driver: applies one cycle of controls and updates the reference model.
  task automatic drive_cycle(input logic s_step, input logic s_shift,
                             input logic s_tdi, input logic s_upd, input string tag);
    @(negedge clk);
    #2;
    dr_step = s_step; dr_shift = s_shift; tdi = s_tdi; dr_upd = s_upd;
    if (s_upd && !(s_step && s_shift)) m_lat = m_sr;
    if (s_step) begin
      if (s_shift) m_sr = {s_tdi, m_sr[L-1:1]};
      else begin
        for (int k = 0; k < NPADS; k++) begin
          m_sr[3*k]   = core_oe[k];
          m_sr[3*k+1] = core_out[k];
          m_sr[3*k+2] = pad_in[k];
        end
      end
    end
    exp_q.push_back(m_sr[0]);
    tag_q.push_back(tag);
  endtask

  task automatic shift_word(input logic [L-1:0] w, input logic s_upd, input string tag);
    for (int i = 0; i < L; i++) drive_cycle(1'b1, 1'b1, w[i], s_upd, tag);
  endtask

  task automatic check_pads(input string tag);
    logic [NPADS-1:0] eo, ee;
    #1;
    for (int k = 0; k < NPADS; k++) begin
      eo[k] = test_mode ? m_lat[3*k+1] : core_out[k];
      ee[k] = test_mode ? m_lat[3*k]   : core_oe[k];
    end
    check({tag, " pad_out"}, {28'd0, pad_out}, {28'd0, eo});
    check({tag, " pad_oe"},  {28'd0, pad_oe},  {28'd0, ee});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    #1;
    check("R1 tdo after reset", {31'd0, tdo}, 32'd0);
    test_mode = 1'b1;
    check_pads("R1 latches after reset");

    // R2/R8: two back-to-back words, the first must reappear at tdo.
    shift_word(12'hA5C, 1'b0, "R2 shift word A");
    shift_word(12'h3B6, 1'b0, "R8 word A emerges after 3N steps");

    // R5/R6: update then drive pads from latches.
    drive_cycle(1'b0, 1'b0, 1'b0, 1'b1, "R5 update pulse");
    drive_cycle(1'b0, 1'b0, 1'b0, 1'b0, "R5 update release");
    check_pads("R6 pads from latches");

    // R5: update strobe held during a shift must not disturb the latches.
    shift_word(12'h5A1, 1'b1, "R5 shift with update high");
    drive_cycle(1'b0, 1'b0, 1'b0, 1'b0, "R5 idle");
    check_pads("R5 latches held through shift");

    // R3: capture distinct per-pad, per-slot patterns.
    core_out = 4'b1010; core_oe = 4'b0110; pad_in = 4'b1101;
    drive_cycle(1'b1, 1'b0, 1'b0, 1'b0, "R3 capture");
    for (int i = 0; i < 5; i++) drive_cycle(1'b1, 1'b1, 1'b0, 1'b0, "R3 captured bits");

    // R4: no step, shift high, tdi toggling: chain frozen.
    for (int i = 0; i < 4; i++) drive_cycle(1'b0, 1'b1, i[0], 1'b0, "R4 frozen without step");
    for (int i = 0; i < 7; i++) drive_cycle(1'b1, 1'b1, 1'b1, 1'b0, "R3 remaining captured bits");

    // R6 again with a fresh update, then R7 with latches nonzero.
    drive_cycle(1'b0, 1'b0, 1'b0, 1'b1, "R5 second update");
    drive_cycle(1'b0, 1'b0, 1'b0, 1'b0, "R5 second release");
    check_pads("R6 pads after second update");
    test_mode = 1'b0;
    core_out = 4'b0011; core_oe = 4'b1001;
    check_pads("R7 normal mode pass-through");
    core_out = 4'b1100; core_oe = 4'b0100;
    check_pads("R7 normal mode follows core");

    drive_cycle(1'b0, 1'b0, 1'b0, 1'b0, "R4 final idle");
    @(negedge clk);
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule